// File: doc/BRIEF.md
# Subcarrier Manchester Response Decoder

This block turns the answer of a contactless tag into bytes. The tag answers with load modulation on a subcarrier and uses Manchester coding. A front end outside this block reports, once per half bit period, whether the subcarrier was present. The decoder works from that stream of half-period flags. It pairs the flags into symbols, checks the opening sequence of the frame and recovers the data bits, least significant bit first. It reports every completed byte as soon as the byte is known, and it reports the outcome of each frame as done or error.

The opening sequence has three symbols. The first symbol is modulated in both halves, and the next two are modulated in the second half only. The bit sense is the reverse of the usual Manchester convention. A frame may be only the opening sequence; the block then reports one marker byte for it. A trailing partial byte is kept, minus its last bit, because that bit belongs to the closing pattern.

When a frame ends, the block gives the byte count and a parity word with one bit per byte. It also gives the frame length in half periods, which the surrounding logic uses as a timestamp offset. Checking the frame CRC is left to later stages.

Top module: `scd_resp_decoder`

## Requirements
- R1: A symbol is two consecutive valid half periods. Bit 1 of the symbol code is the first half and bit 0 is the second half: 00 = none, 01 = late (second half only), 10 = early (first half only), 11 = both. While the decoder is unsynchronised:
  - an unmodulated half is dropped;
  - a modulated half starts a symbol;
  - only a "both" symbol synchronises; any other symbol is ignored with no output.
- R2: The "both" symbol that synchronises must be followed by two "late" symbols. If either of those two symbols is anything else, `frame_err` pulses.
- R3: After the opening sequence:
  - a "late" symbol is bit value 1;
  - an "early" symbol is bit value 0;
  - bits fill a byte from bit 0 upward;
  - the eighth bit completes the byte, which appears on `byte_data` with a one-cycle `byte_valid` pulse.
- R4: For each full byte, the odd-parity bit is shifted into bit 0 of `frame_par`, and older bits move up. The odd-parity bit is the bit that makes the total count of ones in the byte plus that bit odd. `frame_par` is cleared at synchronisation.
- R5: A "both" symbol after at least one data bit ends the frame and pulses `frame_done`.
  - If n ≥ 2 bits are pending, the first n−1 of them are emitted as a right-aligned byte, and a 0 is shifted into `frame_par`.
  - With one or no bit pending, no byte is emitted.
- R6: Each of the following pulses `frame_err`:
  - a "none" symbol while data bits are arriving;
  - a "both" symbol directly after the opening sequence.

  The decoder then spends one wait cycle and returns to the unsynchronised state. `frame_done` and `frame_err` never pulse together.
- R7: A "none" symbol directly after the opening sequence ends the frame. The decoder emits the single marker byte 0x0F with parity bit 1, and `frame_len` is 1.
- R8: At `frame_done`, `frame_halves` gives the number of half periods from the first modulated half of the opening symbol to the last half of the closing symbol. The minimum value is 8.
- R9: Cycles with `hp_valid` low are ignored, so gaps between halves do not change the result. Every result appears two clock edges after the half that completes its symbol has been sampled.
- R10: Under reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hp_valid | input | 1 | A half-period flag is present this cycle |
| hp_mod | input | 1 | The subcarrier was present in that half period |
| byte_valid | output | 1 | One-cycle pulse when a decoded byte is ready |
| byte_data | output | 8 | The decoded byte |
| frame_done | output | 1 | One-cycle pulse when a frame ends correctly |
| frame_err | output | 1 | One-cycle pulse when a frame breaks the coding rules |
| frame_len | output | LEN_W | Bytes in the current frame; final at `frame_done` |
| frame_par | output | PAR_W | Parity bits of the frame, the newest in bit 0 |
| frame_halves | output | DUR_W | Frame length in half periods, updated at `frame_done` |

## Verification
Every result follows the half period that completes its symbol by exactly two clock edges. One edge registers the symbol and the second registers the decision. The bench drives one half period on each falling edge and compares the outputs at the next falling edge with the expectation its model computed one tick earlier. This places every comparison exactly two edges after the stimulus, on every cycle, including idle ones. After each frame the bench leaves a few idle cycles, so the error wait cycle and the return to hunting are settled before the next opening symbol arrives.

// File: rtl/scd_pkg.sv
package scd_pkg;

    // Symbol code: bit 1 = first half modulated, bit 0 = second half modulated
    typedef enum logic [1:0] {
        SYM_NONE  = 2'b00,
        SYM_LATE  = 2'b01,
        SYM_EARLY = 2'b10,
        SYM_BOTH  = 2'b11
    } sym_kind_e;

    typedef struct packed {
        logic      valid;
        sym_kind_e kind;
    } sym_t;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SOF2,
        ST_SOF3,
        ST_SOF_END,
        ST_DATA,
        ST_ERR_WAIT
    } fr_state_e;

    typedef struct packed {
        logic sync;
        logic push;
        logic bit_val;
        logic eof;
        logic sof_only;
        logic done;
        logic err;
    } fr_act_t;

    function automatic logic odd_par_bit(input logic [7:0] b);
        return ~(^b);
    endfunction

    function automatic logic [7:0] low_mask(input logic [2:0] n);
        return (8'd1 << n) - 8'd1;
    endfunction

endpackage

// File: rtl/scd_half_pair.sv
module scd_half_pair
    import scd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hp_valid,
    input  logic hp_mod,
    input  logic hunt,
    output sym_t sym_o
);

    logic phase_q;
    logic first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            first_q <= 1'b0;
            sym_o   <= '0;
        end else begin
            sym_o.valid <= 1'b0;
            if (hp_valid) begin
                if (!phase_q) begin
                    // while hunting, only a modulated half may open a symbol
                    if (hp_mod || !hunt) begin
                        phase_q <= 1'b1;
                        first_q <= hp_mod;
                    end
                end else begin
                    phase_q    <= 1'b0;
                    sym_o.valid <= 1'b1;
                    sym_o.kind  <= sym_kind_e'({first_q, hp_mod});
                end
            end
        end
    end

    AST_HUNT_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (hunt && hp_valid && !hp_mod && !phase_q) |=> !phase_q) else $error("AST_HUNT_DISCARD"); // R1

endmodule

// File: rtl/scd_frame_fsm.sv
module scd_frame_fsm
    import scd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sym_t      sym_i,
    output fr_act_t   act_o,
    output logic      hunt_o,
    output logic      in_frame_o
);

    fr_state_e state_q, nxt;

    always_comb begin
        nxt   = state_q;
        act_o = '0;
        unique case (state_q)
            ST_HUNT: begin
                if (sym_i.valid && sym_i.kind == SYM_BOTH) begin
                    nxt        = ST_SOF2;
                    act_o.sync = 1'b1;
                end
            end
            ST_SOF2, ST_SOF3: begin
                if (sym_i.valid) begin
                    if (sym_i.kind == SYM_LATE) begin
                        nxt = (state_q == ST_SOF2) ? ST_SOF3 : ST_SOF_END;
                    end else begin
                        nxt       = ST_ERR_WAIT;
                        act_o.err = 1'b1;
                    end
                end
            end
            ST_SOF_END: begin
                if (sym_i.valid) begin
                    unique case (sym_i.kind)
                        SYM_NONE: begin
                            nxt            = ST_HUNT;
                            act_o.sof_only = 1'b1;
                            act_o.done     = 1'b1;
                        end
                        SYM_BOTH: begin
                            nxt       = ST_ERR_WAIT;
                            act_o.err = 1'b1;
                        end
                        default: begin
                            nxt           = ST_DATA;
                            act_o.push    = 1'b1;
                            act_o.bit_val = (sym_i.kind == SYM_LATE);
                        end
                    endcase
                end
            end
            ST_DATA: begin
                if (sym_i.valid) begin
                    unique case (sym_i.kind)
                        SYM_NONE: begin
                            nxt       = ST_ERR_WAIT;
                            act_o.err = 1'b1;
                        end
                        SYM_BOTH: begin
                            nxt        = ST_HUNT;
                            act_o.eof  = 1'b1;
                            act_o.done = 1'b1;
                        end
                        default: begin
                            act_o.push    = 1'b1;
                            act_o.bit_val = (sym_i.kind == SYM_LATE);
                        end
                    endcase
                end
            end
            ST_ERR_WAIT: nxt = ST_HUNT;
            default:     nxt = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= nxt;
    end

    assign hunt_o     = (nxt == ST_HUNT) || (nxt == ST_ERR_WAIT);
    assign in_frame_o = (state_q != ST_HUNT) && (state_q != ST_ERR_WAIT);

    AST_GLITCH_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HUNT && sym_i.valid && sym_i.kind != SYM_BOTH) |=> state_q == ST_HUNT) else $error("AST_GLITCH_IGNORED"); // R1
    AST_SOF_DEVIATION: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SOF2 && sym_i.valid && sym_i.kind != SYM_LATE) |=> state_q == ST_ERR_WAIT) else $error("AST_SOF_DEVIATION"); // R2
    AST_ERR_WAIT_ONE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ERR_WAIT) |=> state_q == ST_HUNT) else $error("AST_ERR_WAIT_ONE"); // R6

endmodule

// File: rtl/scd_byte_asm.sv
module scd_byte_asm
    import scd_pkg::*;
#(
    parameter int          LEN_W    = 8,
    parameter int          PAR_W    = 32,
    parameter logic [7:0]  SOF_MARK = 8'h0F
) (
    input  logic             clk,
    input  logic             rst,
    input  fr_act_t          act_i,
    output logic             byte_valid_o,
    output logic [7:0]       byte_data_o,
    output logic [LEN_W-1:0] len_o,
    output logic [PAR_W-1:0] par_o
);

    logic [7:0] shreg_q;
    logic [2:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q      <= '0;
            cnt_q        <= '0;
            byte_valid_o <= 1'b0;
            byte_data_o  <= '0;
            len_o        <= '0;
            par_o        <= '0;
        end else begin
            byte_valid_o <= 1'b0;
            if (act_i.sync) begin
                shreg_q <= '0;
                cnt_q   <= '0;
                len_o   <= '0;
                par_o   <= '0;
            end else if (act_i.sof_only) begin
                byte_valid_o <= 1'b1;
                byte_data_o  <= SOF_MARK;
                len_o        <= len_o + LEN_W'(1);
                par_o        <= {par_o[PAR_W-2:0], odd_par_bit(SOF_MARK)};
            end else if (act_i.push) begin
                if (cnt_q == 3'd7) begin
                    byte_valid_o <= 1'b1;
                    byte_data_o  <= {act_i.bit_val, shreg_q[6:0]};
                    len_o        <= len_o + LEN_W'(1);
                    par_o        <= {par_o[PAR_W-2:0], odd_par_bit({act_i.bit_val, shreg_q[6:0]})};
                    shreg_q      <= '0;
                    cnt_q        <= '0;
                end else begin
                    shreg_q[cnt_q] <= act_i.bit_val;
                    cnt_q          <= cnt_q + 3'd1;
                end
            end else if (act_i.eof) begin
                // the newest bit is part of the closing pattern
                if (cnt_q >= 3'd2) begin
                    byte_valid_o <= 1'b1;
                    byte_data_o  <= shreg_q & low_mask(cnt_q - 3'd1);
                    len_o        <= len_o + LEN_W'(1);
                    par_o        <= {par_o[PAR_W-2:0], 1'b0};
                end
                shreg_q <= '0;
                cnt_q   <= '0;
            end
        end
    end

    AST_SOF_ONLY_BYTE: assert property (@(posedge clk) disable iff (rst)
        act_i.sof_only |=> (byte_valid_o && byte_data_o == SOF_MARK && len_o == LEN_W'(1))) else $error("AST_SOF_ONLY_BYTE"); // R7
    AST_PARTIAL_PAR0: assert property (@(posedge clk) disable iff (rst)
        (act_i.eof && cnt_q >= 3'd2) |=> (byte_valid_o && !par_o[0])) else $error("AST_PARTIAL_PAR0"); // R5
    AST_SHORT_TAIL_DROP: assert property (@(posedge clk) disable iff (rst)
        (act_i.eof && cnt_q < 3'd2) |=> !byte_valid_o) else $error("AST_SHORT_TAIL_DROP"); // R5
    AST_FULL_ODD: assert property (@(posedge clk) disable iff (rst)
        (act_i.push && cnt_q == 3'd7) |=> (($countones({byte_data_o, par_o[0]}) % 2) == 1)) else $error("AST_FULL_ODD"); // R4

endmodule

// File: rtl/scd_resp_decoder.sv
module scd_resp_decoder
    import scd_pkg::*;
#(
    parameter int         LEN_W    = 8,
    parameter int         PAR_W    = 32,
    parameter int         DUR_W    = 12,
    parameter logic [7:0] SOF_MARK = 8'h0F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hp_valid,
    input  logic             hp_mod,
    output logic             byte_valid,
    output logic [7:0]       byte_data,
    output logic             frame_done,
    output logic             frame_err,
    output logic [LEN_W-1:0] frame_len,
    output logic [PAR_W-1:0] frame_par,
    output logic [DUR_W-1:0] frame_halves
);

    sym_t    sym;
    fr_act_t act;
    logic    hunt;
    logic    in_frame;
    logic [DUR_W-1:0] sym_cnt_q;

    scd_half_pair u_pair (
        .clk      (clk),
        .rst      (rst),
        .hp_valid (hp_valid),
        .hp_mod   (hp_mod),
        .hunt     (hunt),
        .sym_o    (sym)
    );

    scd_frame_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sym_i      (sym),
        .act_o      (act),
        .hunt_o     (hunt),
        .in_frame_o (in_frame)
    );

    scd_byte_asm #(
        .LEN_W    (LEN_W),
        .PAR_W    (PAR_W),
        .SOF_MARK (SOF_MARK)
    ) u_asm (
        .clk          (clk),
        .rst          (rst),
        .act_i        (act),
        .byte_valid_o (byte_valid),
        .byte_data_o  (byte_data),
        .len_o        (frame_len),
        .par_o        (frame_par)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_cnt_q    <= '0;
            frame_done   <= 1'b0;
            frame_err    <= 1'b0;
            frame_halves <= '0;
        end else begin
            frame_done <= act.done;
            frame_err  <= act.err;
            if (act.sync) begin
                sym_cnt_q <= DUR_W'(1);
            end else if (sym.valid && in_frame) begin
                sym_cnt_q <= sym_cnt_q + DUR_W'(1);
            end
            if (act.done) begin
                frame_halves <= (sym_cnt_q + DUR_W'(1)) << 1;
            end
        end
    end

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(frame_done && frame_err)) else $error("AST_DONE_ERR_EXCL"); // R6
    AST_MIN_DURATION: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> frame_halves >= DUR_W'(8)) else $error("AST_MIN_DURATION"); // R8

endmodule

// File: tb/scd_resp_decoder_bench.sv
module scd_resp_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hp_valid = 1'b0;
    logic        hp_mod = 1'b0;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        frame_done;
    logic        frame_err;
    logic [7:0]  frame_len;
    logic [31:0] frame_par;
    logic [11:0] frame_halves;

    always #5 clk = ~clk;

    scd_resp_decoder u_scd_resp_decoder (
        .clk          (clk),
        .rst          (rst),
        .hp_valid     (hp_valid),
        .hp_mod       (hp_mod),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .frame_done   (frame_done),
        .frame_err    (frame_err),
        .frame_len    (frame_len),
        .frame_par    (frame_par),
        .frame_halves (frame_halves)
    );

    typedef struct {
        bit          bv;
        logic [7:0]  bd;
        bit          done;
        bit          err;
        int          len;
        logic [31:0] par;
        int          halves;
        string       tag;
    } exp_t;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string phase_tag = "R10";
    exp_t  cur, pend;

    // behavioural model state
    int          m_state = 0;   // 0 hunting, 1..2 opening, 3 after opening, 4 data
    int          m_phase = 0;
    bit          m_first = 0;
    int          m_nsym = 0;
    int          m_len = 0;
    logic [31:0] m_par = '0;
    bit          m_bits[$];

    function automatic void clear_exp(ref exp_t e);
        e.bv = 0; e.bd = '0; e.done = 0; e.err = 0;
        e.len = 0; e.par = '0; e.halves = 0; e.tag = "";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic m_emit(input logic [7:0] b, input bit p, input string t);
        cur.bv = 1; cur.bd = b; cur.tag = t;
        m_len++;
        m_par = {m_par[30:0], p};
    endtask

    task automatic m_finish(input string t);
        cur.done = 1; cur.len = m_len; cur.par = m_par;
        cur.halves = m_nsym * 2; cur.tag = t;
        m_state = 0;
    endtask

    task automatic m_fail(input string t);
        cur.err = 1; cur.tag = t;
        m_state = 0;
    endtask

    task automatic m_symbol(input bit f, input bit s);
        logic [7:0] b;
        case (m_state)
            0: if (f && s) begin
                   m_state = 1; m_nsym = 1; m_len = 0; m_par = '0;
                   m_bits.delete();
               end
            1, 2: begin
                m_nsym++;
                if (!f && s) m_state++;
                else m_fail("R2");
            end
            3: begin
                m_nsym++;
                if (!f && !s) begin
                    m_emit(8'h0F, 1'b1, "R7");
                    m_finish("R7");
                end else if (f && s) begin
                    m_fail("R6");
                end else begin
                    m_bits.push_back(s);
                    m_state = 4;
                end
            end
            default: begin
                m_nsym++;
                if (!f && !s) begin
                    m_fail("R6");
                end else if (f && s) begin
                    if (m_bits.size() >= 2) begin
                        b = '0;
                        for (int i = 0; i < m_bits.size() - 1; i++) b[i] = m_bits[i];
                        m_emit(b, 1'b0, "R5");
                    end
                    m_finish("R5");
                end else begin
                    m_bits.push_back(s);
                    if (m_bits.size() == 8) begin
                        b = '0;
                        for (int i = 0; i < 8; i++) b[i] = m_bits[i];
                        m_emit(b, ~(^b), "R3");
                        m_bits.delete();
                    end
                end
            end
        endcase
    endtask

    task automatic m_half(input bit m);
        if (m_phase == 0) begin
            if (m_state == 0 && !m) return;
            m_first = m;
            m_phase = 1;
        end else begin
            m_phase = 0;
            m_symbol(m_first, m);
        end
    endtask

    task automatic compare(input exp_t e);
        string t;
        t = (e.tag == "") ? phase_tag : e.tag;
        check(byte_valid == e.bv, t, "byte_valid", byte_valid, e.bv);
        check(frame_done == e.done, t, "frame_done", frame_done, e.done);
        check(frame_err == e.err, t, "frame_err", frame_err, e.err);
        if (e.bv) check(byte_data == e.bd, t, "byte_data", byte_data, e.bd);
        if (e.done) begin
            check(frame_len == 8'(e.len), t, "frame_len", frame_len, e.len);
            check(frame_par == e.par, "R4", "frame_par", frame_par, e.par);
            check(frame_halves == 12'(e.halves), "R8", "frame_halves", frame_halves, e.halves);
        end
    endtask

    // drive on a falling edge; compare one falling edge later (two rising edges after sampling)
    task automatic tick(input bit v, input bit m);
        hp_valid = v;
        hp_mod   = m;
        clear_exp(cur);
        if (v) m_half(m);
        @(negedge clk);
        compare(pend);
        pend = cur;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0);
    endtask

    task automatic sym(input bit f, input bit s, input int gap);
        tick(1, f); idle(gap);
        tick(1, s); idle(gap);
    endtask

    task automatic sof(input int gap);
        sym(1, 1, gap); sym(0, 1, gap); sym(0, 1, gap);
    endtask

    task automatic data_bit(input bit b, input int gap);
        sym(!b, b, gap);
    endtask

    task automatic data_byte(input logic [7:0] b, input int gap);
        for (int i = 0; i < 8; i++) data_bit(b[i], gap);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : stim
        clear_exp(cur);
        clear_exp(pend);
        repeat (3) @(negedge clk);
        // R10: reset state
        check(byte_valid == 0 && frame_done == 0 && frame_err == 0, "R10", "pulses", {byte_valid, frame_done, frame_err}, 0);
        check(byte_data == 0 && frame_len == 0 && frame_par == 0 && frame_halves == 0, "R10", "values",
              {byte_data, frame_len, frame_halves}, 0);
        rst = 1'b0;
        idle(3);

        // R1: lone modulated half and unmodulated halves are ignored
        phase_tag = "R1";
        tick(1, 1); tick(1, 0); tick(1, 0); tick(1, 0);
        idle(4);

        // R7: frame with only the opening sequence
        phase_tag = "R7";
        sof(0); sym(0, 0, 0);
        idle(4);

        // R3 / R4: two full bytes closed right after the second byte
        phase_tag = "R3";
        sof(0); data_byte(8'hA5, 0); data_byte(8'h3C, 0); sym(1, 1, 0);
        idle(4);

        // R5: full byte then five bits -> four kept
        phase_tag = "R5";
        sof(0); data_byte(8'h5A, 0);
        data_bit(1, 0); data_bit(0, 0); data_bit(1, 0); data_bit(1, 0); data_bit(0, 0);
        sym(1, 1, 0);
        idle(4);

        // R5: single pending bit is dropped
        sof(0); data_bit(1, 0); sym(1, 1, 0);
        idle(4);

        // R2: bad second and third opening symbols
        phase_tag = "R2";
        sym(1, 1, 0); sym(1, 0, 0);
        idle(4);
        sym(1, 1, 0); sym(0, 1, 0); sym(1, 1, 0);
        idle(4);

        // R6: unmodulated symbol inside data, both-halves before data, then recovery
        phase_tag = "R6";
        sof(0); data_bit(0, 0); data_bit(1, 0); sym(0, 0, 0);
        idle(4);
        sof(0); sym(1, 1, 0);
        idle(4);
        sof(0); data_byte(8'hFF, 0); data_byte(8'h00, 0); sym(1, 1, 0);
        idle(4);

        // R9: gaps between halves
        phase_tag = "R9";
        sof(2); data_byte(8'hC3, 1); data_bit(1, 3); data_bit(1, 1); data_bit(0, 2); sym(1, 1, 2);
        idle(6);

        finished = 1;
        summary();
        $finish;
    end

endmodule